// File: doc/BRIEF.md
# Background/Window Tile Fetch Sequencer

This block orders the video-memory accesses a tile-based display unit makes on one scanline. It runs on a clock at twice the main-clock rate, so one tick is half a main cycle. Every access slot lasts two main cycles, which is four ticks. A scanline begins with a three-slot lead-in: a nametable read, then the low bitplane, then the high bitplane. After that it repeats a four-slot group of nametable, low plane, high plane and a sprite slot. The sprite slot is where sprite reads would be placed.

The horizontal window can start partway along the line. When it does, the background pattern is dropped at once, whatever slot is in progress, and a fresh lead-in begins with window nametable reads. Each line has a budget of ticks that is computed when the line starts. When the budget runs out, the access in progress is cut off, the slot code returns to idle, and a one-tick done flag is raised.

The sequencer reports a slot code for every tick and a strobe when a tile's bitplanes are complete. Address generation, pixel output, vertical timing and the special window positions are handled elsewhere.

Top module: `fetch_tile_sequencer`

## Requirements
- R1: While reset is held and on the first tick after it, the slot code is idle (0), and the tile-ready and line-done outputs are low.
- R2: Each slot lasts 4 ticks. The tick after line_start is sampled is the first tick of the lead-in. The lead-in runs nametable, plane 0 (code 3), plane 1 (code 4). After it, the group nametable, plane 0, plane 1, sprite slot repeats.
- R3: The window is not taken when win_en is low, when win_x is 0, or when win_x is 166 or more. A line that does not take the window lasts 347 + 2*fine_scroll ticks, and every nametable slot in it carries the background name code (1).
- R4: The window is taken when win_en is high and win_x is from 1 to 165. The background phase then lasts 14 + 2*fine_scroll + 2*win_x ticks. The next tick starts a new lead-in whose nametable slots carry the window name code (2), whatever slot the background phase was in.
- R5: A line that takes the window lasts 359 + 2*fine_scroll ticks.
- R6: A sprite slot carries the sprite code (5) for all four ticks if spr_req was high on the clock edge that begins the slot. Otherwise it carries idle (0).
- R7: tile_rdy is high on the fourth tick of each plane-1 slot and on no other tick.
- R8: On the tick after the last tick of the budget, the slot code is idle and line_done is high for exactly one tick. The block then stays idle, with line_done low, until the next line_start.
- R9: A line_start during a line abandons it, and the next tick is the first tick of a new lead-in.
- R10: fine_scroll, win_x and win_en are sampled only on the edge that samples line_start. Changing them later in the line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the main-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Starts a scanline (restarts one in flight) |
| fine_scroll | input | 3 | Fine horizontal scroll, 0 to 7 |
| win_x | input | 8 | Window horizontal position |
| win_en | input | 1 | Window enable |
| spr_req | input | 1 | Sprite fetch wanted in the coming sprite slot |
| slot_code | output | 3 | 0 idle, 1 background name, 2 window name, 3 plane 0, 4 plane 1, 5 sprite |
| tile_rdy | output | 1 | Last tick of a completed plane-1 slot |
| line_done | output | 1 | One-tick pulse after the budget expires |

## Verification
The hardest cases to reach are the window restart landing in each of the four slot positions and each of the four ticks within a slot, and the budget cutting off each kind of access. Both positions depend on fine_scroll and win_x together. The bench therefore sweeps every fine scroll value against a set of window positions that includes the boundaries 0, 1, 165 and 166. For each tick it computes the expected slot position arithmetically from the tick index. spr_req follows a tick-dependent pattern so that both sprite outcomes occur. Some lines also change the configuration inputs on every tick after the start, and others are pre-empted by a second line_start.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    // Slot codes presented on the output every tick.
    typedef enum logic [2:0] {
        SLOT_IDLE     = 3'd0,
        SLOT_BG_NAME  = 3'd1,
        SLOT_WIN_NAME = 3'd2,
        SLOT_PLANE0   = 3'd3,
        SLOT_PLANE1   = 3'd4,
        SLOT_SPRITE   = 3'd5
    } slot_code_e;

    // Position inside the access pattern.
    typedef enum logic [1:0] {
        K_NAME = 2'd0,
        K_LO   = 2'd1,
        K_HI   = 2'd2,
        K_SPR  = 2'd3
    } slot_kind_e;

endpackage

// File: rtl/fetch_budget.sv
// Computes the line budget and the background-phase length from the
// configuration presented at line start. Pure combinational.
module fetch_budget #(
    parameter int FINE_W        = 3,
    parameter int WX_W          = 8,
    parameter int CNT_W         = 10,
    parameter int TICKS_PER_CYC = 2,
    parameter int SLOT_CYC      = 2,
    parameter int LEAD_SLOTS    = 3,
    parameter int BASE_TICKS    = 347,
    parameter int WX_LIMIT      = 166
) (
    input  logic [FINE_W-1:0] fine_scroll,
    input  logic [WX_W-1:0]   win_x,
    input  logic              win_en,
    output logic              win_hit,
    output logic [CNT_W-1:0]  total_ticks,
    output logic [CNT_W-1:0]  bg_ticks
);
    localparam int SLOT_TICKS = TICKS_PER_CYC * SLOT_CYC;
    localparam int LEAD_TICKS = LEAD_SLOTS * SLOT_TICKS;

    logic [CNT_W-1:0] fine_t;
    logic [CNT_W-1:0] wx_t;

    always_comb begin
        fine_t  = CNT_W'(TICKS_PER_CYC) * CNT_W'(fine_scroll);
        wx_t    = CNT_W'(TICKS_PER_CYC) * CNT_W'(win_x);
        win_hit = win_en && (win_x != '0) && (int'(win_x) < WX_LIMIT);
        // The window adds one extra lead-in to the line.
        total_ticks = CNT_W'(BASE_TICKS) + fine_t
                    + (win_hit ? CNT_W'(LEAD_TICKS) : '0);
        // Lead-in plus (fine + window X + 1) main cycles.
        bg_ticks = CNT_W'(LEAD_TICKS) + fine_t + wx_t + CNT_W'(TICKS_PER_CYC);
    end
endmodule

// File: rtl/fetch_timer.sv
// Down-counters for the line budget and the window trigger.
module fetch_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             win_hit,
    input  logic [CNT_W-1:0] total_ticks,
    input  logic [CNT_W-1:0] bg_ticks,
    output logic             active,
    output logic             win_fire,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic [CNT_W-1:0] win_left;
        logic             done;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (start) begin
            tm_d.remain   = total_ticks;
            tm_d.win_left = win_hit ? bg_ticks : '0;
            tm_d.done     = 1'b0;
        end else begin
            tm_d.done = (tm_q.remain == CNT_W'(1));
            if (tm_q.remain != '0)   tm_d.remain   = tm_q.remain - CNT_W'(1);
            if (tm_q.win_left != '0) tm_d.win_left = tm_q.win_left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign active   = (tm_q.remain != '0);
    assign win_fire = (tm_q.win_left == CNT_W'(1));
    assign done     = tm_q.done;
endmodule

// File: rtl/fetch_slot_walker.sv
// Steps through the lead-in and the repeating slot group.
module fetch_slot_walker
    import fetch_seq_pkg::*;
#(
    parameter int SLOT_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic       win_fire,
    input  logic       spr_req,
    output slot_code_e code,
    output logic       tile_rdy
);
    localparam int SUB_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_TICKS - 1);

    typedef struct packed {
        slot_kind_e       kind;
        logic [SUB_W-1:0] sub;
        logic             lead;
        logic             win_phase;
        logic             spr;
    } walk_t;

    walk_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (start) begin
            wk_d.kind      = K_NAME;
            wk_d.sub       = '0;
            wk_d.lead      = 1'b1;
            wk_d.win_phase = 1'b0;
            wk_d.spr       = 1'b0;
        end else if (active && win_fire) begin
            // Window restart: drop whatever slot is in progress.
            wk_d.kind      = K_NAME;
            wk_d.sub       = '0;
            wk_d.lead      = 1'b1;
            wk_d.win_phase = 1'b1;
        end else if (active) begin
            if (wk_q.sub == SUB_LAST) begin
                wk_d.sub = '0;
                unique case (wk_q.kind)
                    K_NAME: wk_d.kind = K_LO;
                    K_LO:   wk_d.kind = K_HI;
                    K_HI: begin
                        if (wk_q.lead) begin
                            wk_d.lead = 1'b0;
                            wk_d.kind = K_NAME;
                        end else begin
                            wk_d.kind = K_SPR;
                            wk_d.spr  = spr_req;
                        end
                    end
                    default: wk_d.kind = K_NAME;
                endcase
            end else begin
                wk_d.sub = wk_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    always_comb begin
        code = SLOT_IDLE;
        if (active) begin
            unique case (wk_q.kind)
                K_NAME:  code = wk_q.win_phase ? SLOT_WIN_NAME : SLOT_BG_NAME;
                K_LO:    code = SLOT_PLANE0;
                K_HI:    code = SLOT_PLANE1;
                default: code = wk_q.spr ? SLOT_SPRITE : SLOT_IDLE;
            endcase
        end
    end

    assign tile_rdy = active && (wk_q.kind == K_HI) && (wk_q.sub == SUB_LAST);
endmodule

// File: rtl/fetch_tile_sequencer.sv
module fetch_tile_sequencer
    import fetch_seq_pkg::*;
#(
    parameter int FINE_W        = 3,
    parameter int WX_W          = 8,
    parameter int CNT_W         = 10,
    parameter int TICKS_PER_CYC = 2,
    parameter int SLOT_CYC      = 2,
    parameter int BASE_TICKS    = 347,
    parameter int WX_LIMIT      = 166
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [FINE_W-1:0] fine_scroll,
    input  logic [WX_W-1:0]   win_x,
    input  logic              win_en,
    input  logic              spr_req,
    output logic [2:0]        slot_code,
    output logic              tile_rdy,
    output logic              line_done
);
    localparam int SLOT_TICKS = TICKS_PER_CYC * SLOT_CYC;

    logic             win_hit_w;
    logic [CNT_W-1:0] total_w;
    logic [CNT_W-1:0] bg_w;
    logic             active_w;
    logic             fire_w;
    slot_code_e       code_w;

    fetch_budget #(
        .FINE_W(FINE_W), .WX_W(WX_W), .CNT_W(CNT_W),
        .TICKS_PER_CYC(TICKS_PER_CYC), .SLOT_CYC(SLOT_CYC),
        .LEAD_SLOTS(3), .BASE_TICKS(BASE_TICKS), .WX_LIMIT(WX_LIMIT)
    ) budget_i (
        .fine_scroll(fine_scroll),
        .win_x(win_x),
        .win_en(win_en),
        .win_hit(win_hit_w),
        .total_ticks(total_w),
        .bg_ticks(bg_w)
    );

    fetch_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk),
        .rst_n(rst_n),
        .start(line_start),
        .win_hit(win_hit_w),
        .total_ticks(total_w),
        .bg_ticks(bg_w),
        .active(active_w),
        .win_fire(fire_w),
        .done(line_done)
    );

    fetch_slot_walker #(.SLOT_TICKS(SLOT_TICKS)) walker_i (
        .clk(clk),
        .rst_n(rst_n),
        .start(line_start),
        .active(active_w),
        .win_fire(fire_w),
        .spr_req(spr_req),
        .code(code_w),
        .tile_rdy(tile_rdy)
    );

    assign slot_code = code_w;
endmodule

// File: rtl/fetch_tile_sequencer_chk.sv
module fetch_tile_sequencer_chk #(
    parameter int FINE_W = 3,
    parameter int WX_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic [FINE_W-1:0] fine_scroll,
    input logic [WX_W-1:0]   win_x,
    input logic              win_en,
    input logic              spr_req,
    input logic [2:0]        slot_code,
    input logic              tile_rdy,
    input logic              line_done
);
    logic [2:0] prev_code_q;
    logic [2:0] run_q;
    logic [2:0] run_now;

    // Length of the current unchanged run of slot codes, minus one.
    assign run_now = (slot_code == prev_code_q)
                   ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code_q <= 3'd0;
            run_q       <= 3'd0;
        end else begin
            prev_code_q <= slot_code;
            run_q       <= run_now;
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> slot_code == 3'd0);

    assert_rdy_fourth_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tile_rdy |-> (slot_code == 3'd4 && run_now == 3'd3));

    assert_start_leads_name_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_start) |-> slot_code == 3'd1);
endmodule

bind fetch_tile_sequencer fetch_tile_sequencer_chk #(.FINE_W(FINE_W), .WX_W(WX_W)) chk_i (.*);

// File: tb/fetch_tile_sequencer_tb.sv
module fetch_tile_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_start;
    logic [2:0] fine_scroll;
    logic [7:0] win_x;
    logic       win_en;
    logic       spr_req;
    logic [2:0] slot_code;
    logic       tile_rdy;
    logic       line_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fetch_tile_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .fine_scroll(fine_scroll), .win_x(win_x), .win_en(win_en),
        .spr_req(spr_req), .slot_code(slot_code), .tile_rdy(tile_rdy),
        .line_done(line_done)
    );

    function automatic bit spr_pat(int t, int id);
        return bit'(((t * 7 + id * 3) >> 3) & 1);
    endfunction

    task automatic cmp(string tag, int t, int exp_c, bit exp_r, bit exp_d);
        checks++;
        if (slot_code !== 3'(exp_c) || tile_rdy !== exp_r || line_done !== exp_d) begin
            errors++;
            $display("FAIL %s tick %0d: got code=%0d rdy=%0b done=%0b expected code=%0d rdy=%0b done=%0b",
                     tag, t, slot_code, tile_rdy, line_done, exp_c, exp_r, exp_d);
        end
    endtask

    // Runs one line from the current negedge. A nonzero cut stops after
    // tick cut-1 so the caller can pre-empt the line (R9).
    task automatic run_line(int f, int wx, bit en, int id, int cut, bit scramble, bit after_cut);
        bit hit;
        int bglen, total;
        hit   = en && wx > 0 && wx < 166;
        bglen = 14 + 2 * f + 2 * wx;
        total = hit ? 359 + 2 * f : 347 + 2 * f;
        fine_scroll = 3'(f);
        win_x       = 8'(wx);
        win_en      = en;
        line_start  = 1'b1;
        for (int t = 0; t <= total; t++) begin
            @(negedge clk);
            line_start = 1'b0;
            if (scramble) begin
                // R10: later configuration changes must be ignored
                fine_scroll = 3'(t * 5 + id);
                win_x       = 8'(t * 37 + id);
                win_en      = ~win_en;
            end
            spr_req = spr_pat(t, id);
            if (t < total) begin
                bit isw;
                int u, kind, sub, ec;
                bit er;
                string tag;
                isw  = hit && t >= bglen;
                u    = isw ? t - bglen : t;
                kind = (u < 12) ? u / 4 : ((u - 12) % 16) / 4;
                sub  = u % 4;
                case (kind)
                    0: ec = isw ? 2 : 1;
                    1: ec = 3;
                    2: ec = 4;
                    default: ec = spr_pat(t - sub - 1, id) ? 5 : 0;
                endcase
                er = (kind == 2 && sub == 3);
                if (after_cut && t == 0)      tag = "R9";
                else if (tile_rdy !== er)     tag = "R7";
                else if (kind == 3)           tag = "R6";
                else if (isw)                 tag = "R4";
                else if (!hit)                tag = "R3";
                else                          tag = "R2";
                if (scramble) tag = {tag, " (R10 config held)"};
                cmp(tag, t, ec, er, 1'b0);
            end else begin
                cmp(hit ? "R5 budget end/R8" : "R3 budget end/R8", t, 0, 1'b0, 1'b1);
            end
            if (cut != 0 && t == cut - 1) return;
        end
        @(negedge clk);
        spr_req = 1'b0;
        cmp("R8 single done", total + 1, 0, 1'b0, 1'b0);
    endtask

    int wx_set[10] = '{0, 1, 2, 3, 50, 100, 164, 165, 166, 200};

    initial begin
        int id;
        id = 0;
        rst_n = 1'b0; line_start = 1'b0; fine_scroll = '0; win_x = '0;
        win_en = 1'b0; spr_req = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R1 in reset", 0, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset", 0, 0, 1'b0, 1'b0);

        for (int en = 0; en < 2; en++) begin
            for (int f = 0; f < 8; f++) begin
                for (int w = 0; w < 10; w++) begin
                    run_line(f, wx_set[w], bit'(en), id, 0, (id % 3) == 0, 1'b0);
                    id++;
                end
            end
        end

        // R8: stays idle with no done until a new start
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cmp("R8 idle gap", k, 0, 1'b0, 1'b0);
        end

        // R9: pre-empt a line in the background phase, in the window phase,
        // and partway through a slot.
        run_line(3, 50, 1'b1, id, 100, 1'b0, 1'b0); id++;
        run_line(5, 0, 1'b0, id, 0, 1'b0, 1'b1); id++;
        run_line(2, 120, 1'b1, id, 300, 1'b0, 1'b0); id++;
        run_line(7, 10, 1'b1, id, 47, 1'b0, 1'b1); id++;
        run_line(0, 165, 1'b1, id, 0, 1'b0, 1'b1); id++;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired after 200000 cycles");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule